// File: doc/BRIEF.md
# Dual-Bank Memory Access Controller

This controller sits between a host bus slave port and the memories on an accelerator card. The memories are two 32-bit user SRAM banks, a slow byte-wide configuration RAM and a byte-wide identification ROM. The controller decodes each host address into a region and steers byte and halfword accesses onto the right lanes of the 32-bit banks. It arbitrates each bank between the host and the local compute logic. The card's small control and status register set is also held here.

A host access is one request held high until a single-cycle `host_ready` pulse. Requests to the banks may wait while the local logic owns a bank. Memories are synchronous: the controller issues in one cycle, and read data is returned with `host_ready` in the next. Setting the mirror enable makes every host write aimed at either user bank land in both banks in the same cycle. This allows identical tables to be loaded into the two banks at once.

Top module: `dual_bank_hub`

## Requirements
- R1: Host addresses decode as follows. 0x000000–0x007FFF is the ROM, 0x100000–0x17FFFF is the configuration RAM, 0x200000–0x2FFFFF is bank 0, 0x300000–0x3FFFFF is bank 1, and 0x400000–0x400005 are the registers. An accepted access completes with exactly one `host_ready` cycle, in the cycle after it is issued. Bank word address = host_addr[19:2].
- R2: Sizes are host_size 0 = byte, 1 = halfword, 2 = word. Lanes are big-endian: byte offset k uses bits [31-8k -: 8]. A halfword at offset 0 uses bits 31:16 and at offset 2 uses bits 15:0. Write data is taken from the low bits of host_wdata, and read data is returned right-justified.
- R3: A halfword at an odd offset, or a word at a non-zero offset, to a bank is an address error and changes no memory.
- R4: While mirror enable is 1, a host write to either bank is written to the same word of both banks in one cycle. While it is 0, only the addressed bank changes.
- R5: While `core_run` is 1, a local request to a bank is always granted. A host access to that bank waits with `host_ready` low until the bank is free.
- R6: While `core_run` is 0, a host access issuing to a bank wins over a local request, which sees `loc_gnt` low in that cycle.
- R7: Register offsets, with data in bits 7:0, are:
  - 0 status: reads `status_in`, read-only.
  - 1 configuration select: read/write, 2 bits, drives `cfg_sel`.
  - 2 interrupt cause: 3 bits, read-only.
  - 3 clock program: write-only, 4 bits, drives `clk_prog`.
  - 4 command: write-only, 3 bits.
  - 5 mirror enable: write-only, bit 0.
  Reads of write-only registers return 0.
- R8: Writing the command register produces the written 3-bit value on `cmd_pulse` for exactly one cycle.
- R9: Cause bit 0 is set by `done_in`, bit 1 by an address error and bit 2 by `fault_in`. Reading the cause register clears it. `irq` is the OR of the cause bits.
- R10: An unmapped address, or a write to the status register, the cause register or the ROM, is an address error. It still completes, and its read data is 0.
- R11: After reset, `host_ready`, `irq`, `cfg_sel`, `clk_prog`, `cmd_pulse` and the bank enables are 0, and mirroring is off.
- R12: The ROM and the configuration RAM are byte-wide for every size. Write data comes from host_wdata[7:0] and read data is returned in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_req | input | 1 | Host access request, held until ready |
| host_we | input | 1 | Host write |
| host_size | input | 2 | 0 byte, 1 halfword, 2 word |
| host_addr | input | 24 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | Access complete pulse |
| host_rdata | output | 32 | Host read data, valid with ready |
| core_run | input | 1 | Local logic running (local priority) |
| loc_req | input | 2 | Local request per bank |
| loc_we | input | 2 | Local write per bank |
| loc_addr | input | 36 | Local word address per bank (18 bits each) |
| loc_be | input | 8 | Local byte enables per bank |
| loc_wdata | input | 64 | Local write data per bank |
| loc_gnt | output | 2 | Local grant per bank |
| bank_en | output | 2 | Bank enable |
| bank_we | output | 2 | Bank write |
| bank_addr | output | 36 | Bank word address |
| bank_be | output | 8 | Bank byte enables, bit 3 = bits 31:24 |
| bank_wdata | output | 64 | Bank write data |
| bank_rdata | input | 64 | Bank read data, one cycle after enable |
| cram_en | output | 1 | Configuration RAM enable |
| cram_we | output | 1 | Configuration RAM write |
| cram_addr | output | 19 | Configuration RAM byte address |
| cram_wdata | output | 8 | Configuration RAM write data |
| cram_rdata | input | 8 | Configuration RAM read data |
| rom_en | output | 1 | ROM enable |
| rom_addr | output | 15 | ROM byte address |
| rom_rdata | input | 8 | ROM read data |
| status_in | input | 4 | Status presented in the status register |
| done_in | input | 1 | Completion event |
| fault_in | input | 1 | Fault event |
| cfg_sel | output | 2 | Selected configuration |
| clk_prog | output | 4 | Clock program value |
| cmd_pulse | output | 3 | Command strobe |
| irq | output | 1 | Interrupt request |

## Verification
A wrong lane mask or shift shows up as a wrong value on the next read of the same word. It is visible two host accesses after the fault. A mirror flag stuck in the wrong state shows as a stale or overwritten word in the other bank on the first cross-bank read. An arbitration fault is visible in the issue cycle itself: either `host_ready` rises while the local logic holds the bank, or `loc_gnt` drops while `core_run` is high. Cause-register faults appear on `irq` the cycle after the event, and in the value read back from offset 2.

// File: rtl/hub_pkg.sv
package hub_pkg;

    typedef enum logic [2:0] {
        RG_NONE  = 3'd0,
        RG_ROM   = 3'd1,
        RG_CRAM  = 3'd2,
        RG_BANK0 = 3'd3,
        RG_BANK1 = 3'd4,
        RG_REG   = 3'd5
    } region_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic [2:0] RIX_STATUS = 3'd0;
    localparam logic [2:0] RIX_CFG    = 3'd1;
    localparam logic [2:0] RIX_CAUSE  = 3'd2;
    localparam logic [2:0] RIX_CLK    = 3'd3;
    localparam logic [2:0] RIX_CMD    = 3'd4;
    localparam logic [2:0] RIX_MIRROR = 3'd5;

    // big-endian lane mask: mask bit 3 selects data bits 31:24
    function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] ofs);
        logic [3:0] m;
        case (sz)
            SZ_BYTE: m = 4'b1000 >> ofs;
            SZ_HALF: m = ofs[1] ? 4'b0011 : 4'b1100;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

    function automatic logic [31:0] lane_wdata(input logic [1:0] sz, input logic [31:0] d);
        logic [31:0] r;
        case (sz)
            SZ_BYTE: r = {4{d[7:0]}};
            SZ_HALF: r = {2{d[15:0]}};
            default: r = d;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] lane_rdata(input logic [1:0] sz, input logic [1:0] ofs,
                                               input logic [31:0] w);
        logic [31:0] r;
        case (sz)
            SZ_BYTE: begin
                case (ofs)
                    2'd0:    r = {24'b0, w[31:24]};
                    2'd1:    r = {24'b0, w[23:16]};
                    2'd2:    r = {24'b0, w[15:8]};
                    default: r = {24'b0, w[7:0]};
                endcase
            end
            SZ_HALF: r = ofs[1] ? {16'b0, w[15:0]} : {16'b0, w[31:16]};
            default: r = w;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hub_decode.sv
module hub_decode
    import hub_pkg::*;
#(
    parameter int AW      = 24,
    parameter int REG_CNT = 6
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic          we,
    output region_e       region,
    output logic [2:0]    reg_idx,
    output logic          err
);
    localparam int SEL_LO = AW - 4;

    logic [3:0] sel;
    logic       misal;
    logic       ro_wr;

    assign sel     = addr[AW-1:SEL_LO];
    assign reg_idx = addr[2:0];

    always_comb begin
        region = RG_NONE;
        case (sel)
            4'h0: if (addr[SEL_LO-1:15] == '0) region = RG_ROM;
            4'h1: if (!addr[SEL_LO-1]) region = RG_CRAM;
            4'h2: region = RG_BANK0;
            4'h3: region = RG_BANK1;
            4'h4: if (addr[SEL_LO-1:3] == '0 && 32'(addr[2:0]) < REG_CNT) region = RG_REG;
            default: region = RG_NONE;
        endcase
    end

    always_comb begin
        misal = 1'b0;
        if (region == RG_BANK0 || region == RG_BANK1) begin
            case (size)
                SZ_BYTE: misal = 1'b0;
                SZ_HALF: misal = addr[0];
                default: misal = (addr[1:0] != 2'b00);
            endcase
        end
    end

    assign ro_wr = we && ((region == RG_ROM) ||
                          (region == RG_REG && (reg_idx == RIX_STATUS || reg_idx == RIX_CAUSE)));

    assign err = (region == RG_NONE) || misal || ro_wr;

endmodule

// File: rtl/hub_regs.sv
module hub_regs
    import hub_pkg::*;
#(
    parameter int CFG_W    = 2,
    parameter int CLK_W    = 4,
    parameter int CMD_W    = 3,
    parameter int STAT_W   = 4,
    parameter int CAUSE_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        idx,
    input  logic [7:0]        wdata,
    input  logic [STAT_W-1:0] status_in,
    input  logic              done_in,
    input  logic              fault_in,
    input  logic              err_set,
    output logic [7:0]        rdata,
    output logic [CFG_W-1:0]  cfg_sel,
    output logic [CLK_W-1:0]  clk_prog,
    output logic [CMD_W-1:0]  cmd_pulse,
    output logic              mirror,
    output logic              irq
);
    localparam int C_DONE  = 0;
    localparam int C_ERR   = 1;
    localparam int C_FAULT = 2;

    typedef struct packed {
        logic [CFG_W-1:0]   cfg;
        logic [CLK_W-1:0]   clkp;
        logic [CMD_W-1:0]   cmd;
        logic               mir;
        logic [CAUSE_W-1:0] cause;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        logic [CAUSE_W-1:0] setv;
        r_d     = r_q;
        r_d.cmd = '0;
        setv    = '0;
        setv[C_DONE]  = done_in;
        setv[C_ERR]   = err_set;
        setv[C_FAULT] = fault_in;
        if (wr_en) begin
            case (idx)
                RIX_CFG:    r_d.cfg  = wdata[CFG_W-1:0];
                RIX_CLK:    r_d.clkp = wdata[CLK_W-1:0];
                RIX_CMD:    r_d.cmd  = wdata[CMD_W-1:0];
                RIX_MIRROR: r_d.mir  = wdata[0];
                default: ;
            endcase
        end
        if (rd_en && idx == RIX_CAUSE) r_d.cause = '0;
        r_d.cause = r_d.cause | setv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (idx)
            RIX_STATUS: rdata = 8'(status_in);
            RIX_CFG:    rdata = 8'(r_q.cfg);
            RIX_CAUSE:  rdata = 8'(r_q.cause);
            default:    rdata = '0;
        endcase
    end

    assign cfg_sel   = r_q.cfg;
    assign clk_prog  = r_q.clkp;
    assign cmd_pulse = r_q.cmd;
    assign mirror    = r_q.mir;
    assign irq       = |r_q.cause;

    a_r8_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse != '0) |=> (cmd_pulse == '0));
    a_r9_done_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        done_in |=> irq);
    a_r9_fault_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |=> irq);

endmodule

// File: rtl/hub_bank_arb.sv
module hub_bank_arb #(
    parameter int AW = 18,
    parameter int DW = 32,
    localparam int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_run,
    input  logic          loc_req,
    input  logic          loc_we,
    input  logic [AW-1:0] loc_addr,
    input  logic [BW-1:0] loc_be,
    input  logic [DW-1:0] loc_wdata,
    output logic          loc_gnt,
    output logic          host_ok,
    input  logic          host_go,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [BW-1:0] host_be,
    input  logic [DW-1:0] host_wdata,
    output logic          bank_en,
    output logic          bank_we,
    output logic [AW-1:0] bank_addr,
    output logic [BW-1:0] bank_be,
    output logic [DW-1:0] bank_wdata
);
    // local side owns the bank while running; otherwise the host wins
    assign host_ok = !(core_run && loc_req);
    assign loc_gnt = loc_req && !host_go;

    always_comb begin
        if (host_go) begin
            bank_en    = 1'b1;
            bank_we    = host_we;
            bank_addr  = host_addr;
            bank_be    = host_be;
            bank_wdata = host_wdata;
        end else begin
            bank_en    = loc_gnt;
            bank_we    = loc_gnt && loc_we;
            bank_addr  = loc_addr;
            bank_be    = loc_be;
            bank_wdata = loc_wdata;
        end
    end

    a_r2_host_write_has_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (host_go && host_we) |-> (bank_be != '0));

endmodule

// File: rtl/dual_bank_hub.sv
module dual_bank_hub
    import hub_pkg::*;
#(
    parameter int HAW     = 24,
    parameter int DW      = 32,
    parameter int NB      = 2,
    parameter int BANK_AW = 18,
    parameter int CRAM_AW = 19,
    parameter int ROM_AW  = 15,
    parameter int REG_CNT = 6,
    localparam int BW     = DW / 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_req,
    input  logic                  host_we,
    input  logic [1:0]            host_size,
    input  logic [HAW-1:0]        host_addr,
    input  logic [DW-1:0]         host_wdata,
    output logic                  host_ready,
    output logic [DW-1:0]         host_rdata,
    input  logic                  core_run,
    input  logic [NB-1:0]         loc_req,
    input  logic [NB-1:0]         loc_we,
    input  logic [NB*BANK_AW-1:0] loc_addr,
    input  logic [NB*BW-1:0]      loc_be,
    input  logic [NB*DW-1:0]      loc_wdata,
    output logic [NB-1:0]         loc_gnt,
    output logic [NB-1:0]         bank_en,
    output logic [NB-1:0]         bank_we,
    output logic [NB*BANK_AW-1:0] bank_addr,
    output logic [NB*BW-1:0]      bank_be,
    output logic [NB*DW-1:0]      bank_wdata,
    input  logic [NB*DW-1:0]      bank_rdata,
    output logic                  cram_en,
    output logic                  cram_we,
    output logic [CRAM_AW-1:0]    cram_addr,
    output logic [7:0]            cram_wdata,
    input  logic [7:0]            cram_rdata,
    output logic                  rom_en,
    output logic [ROM_AW-1:0]     rom_addr,
    input  logic [7:0]            rom_rdata,
    input  logic [3:0]            status_in,
    input  logic                  done_in,
    input  logic                  fault_in,
    output logic [1:0]            cfg_sel,
    output logic [3:0]            clk_prog,
    output logic [2:0]            cmd_pulse,
    output logic                  irq
);
    typedef struct packed {
        logic       busy;
        region_e    region;
        logic [1:0] ofs;
        logic [1:0] size;
        logic [7:0] hold;
    } host_st_t;

    host_st_t st_q, st_d;

    region_e    dec_region;
    logic [2:0] dec_idx;
    logic       dec_err;
    logic       mirror;
    logic [7:0] reg_rdata;
    logic       mirror_wr;
    logic [NB-1:0] use_bank, bank_ok;
    logic       banks_free;
    logic       issue;
    logic       reg_wr, reg_rd;
    logic [BW-1:0] h_be;
    logic [DW-1:0] h_wd;

    hub_decode #(.AW(HAW), .REG_CNT(REG_CNT)) u_decode (
        .addr    (host_addr),
        .size    (host_size),
        .we      (host_we),
        .region  (dec_region),
        .reg_idx (dec_idx),
        .err     (dec_err)
    );

    assign mirror_wr = mirror && host_we && !dec_err &&
                       (dec_region == RG_BANK0 || dec_region == RG_BANK1);

    assign use_bank[0] = !dec_err && (dec_region == RG_BANK0 || mirror_wr);
    assign use_bank[1] = !dec_err && (dec_region == RG_BANK1 || mirror_wr);

    assign banks_free = &(~use_bank | bank_ok);
    assign issue      = !st_q.busy && host_req && banks_free;

    assign reg_wr = issue && !dec_err && dec_region == RG_REG && host_we;
    assign reg_rd = issue && !dec_err && dec_region == RG_REG && !host_we;

    assign h_be = lane_mask(host_size, host_addr[1:0]);
    assign h_wd = lane_wdata(host_size, host_wdata);

    genvar b;
    generate
        for (b = 0; b < NB; b++) begin : g_bank
            hub_bank_arb #(.AW(BANK_AW), .DW(DW)) u_arb (
                .clk        (clk),
                .rst_n      (rst_n),
                .core_run   (core_run),
                .loc_req    (loc_req[b]),
                .loc_we     (loc_we[b]),
                .loc_addr   (loc_addr[b*BANK_AW +: BANK_AW]),
                .loc_be     (loc_be[b*BW +: BW]),
                .loc_wdata  (loc_wdata[b*DW +: DW]),
                .loc_gnt    (loc_gnt[b]),
                .host_ok    (bank_ok[b]),
                .host_go    (issue && use_bank[b]),
                .host_we    (host_we),
                .host_addr  (host_addr[BANK_AW+1:2]),
                .host_be    (h_be),
                .host_wdata (h_wd),
                .bank_en    (bank_en[b]),
                .bank_we    (bank_we[b]),
                .bank_addr  (bank_addr[b*BANK_AW +: BANK_AW]),
                .bank_be    (bank_be[b*BW +: BW]),
                .bank_wdata (bank_wdata[b*DW +: DW])
            );

            a_r5_local_priority: assert property (@(posedge clk) disable iff (!rst_n)
                (core_run && loc_req[b]) |-> loc_gnt[b]);
        end
    endgenerate

    hub_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .rd_en     (reg_rd),
        .idx       (dec_idx),
        .wdata     (host_wdata[7:0]),
        .status_in (status_in),
        .done_in   (done_in),
        .fault_in  (fault_in),
        .err_set   (issue && dec_err),
        .rdata     (reg_rdata),
        .cfg_sel   (cfg_sel),
        .clk_prog  (clk_prog),
        .cmd_pulse (cmd_pulse),
        .mirror    (mirror),
        .irq       (irq)
    );

    assign rom_en     = issue && !dec_err && dec_region == RG_ROM;
    assign rom_addr   = host_addr[ROM_AW-1:0];
    assign cram_en    = issue && !dec_err && dec_region == RG_CRAM;
    assign cram_we    = cram_en && host_we;
    assign cram_addr  = host_addr[CRAM_AW-1:0];
    assign cram_wdata = host_wdata[7:0];

    always_comb begin
        st_d      = st_q;
        st_d.busy = 1'b0;
        if (issue) begin
            st_d.busy   = 1'b1;
            st_d.region = dec_err ? RG_NONE : dec_region;
            st_d.ofs    = host_addr[1:0];
            st_d.size   = host_size;
            st_d.hold   = (dec_err || dec_region != RG_REG) ? 8'h00 : reg_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_ready = st_q.busy;

    always_comb begin
        case (st_q.region)
            RG_BANK0: host_rdata = lane_rdata(st_q.size, st_q.ofs, bank_rdata[0 +: DW]);
            RG_BANK1: host_rdata = lane_rdata(st_q.size, st_q.ofs, bank_rdata[DW +: DW]);
            RG_ROM:   host_rdata = {{(DW-8){1'b0}}, rom_rdata};
            RG_CRAM:  host_rdata = {{(DW-8){1'b0}}, cram_rdata};
            default:  host_rdata = {{(DW-8){1'b0}}, st_q.hold};
        endcase
    end

    a_r1_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);
    a_r4_mirror_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_en[0] && bank_we[0] && !loc_gnt[0] && mirror) |->
        (bank_en[1] && bank_we[1] && bank_wdata[0 +: DW] == bank_wdata[DW +: DW]));
    a_r10_err_no_memory: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_err) |-> (!rom_en && !cram_en && (bank_en & ~loc_gnt) == '0));

endmodule

// File: tb/dual_bank_hub_bench.sv
`timescale 1ns/1ps
module dual_bank_hub_bench;

    logic clk = 0;
    logic rst_n = 0;
    always #4 clk = ~clk;

    logic        h_req = 0, h_we = 0;
    logic [1:0]  h_size = 0;
    logic [23:0] h_addr = 0;
    logic [31:0] h_wdata = 0;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic        core_run = 0;
    logic [1:0]  loc_req = 0, loc_we = 0;
    logic [35:0] loc_addr = 0;
    logic [7:0]  loc_be = 0;
    logic [63:0] loc_wdata = 0;
    logic [1:0]  loc_gnt, bank_en, bank_we;
    logic [35:0] bank_addr;
    logic [7:0]  bank_be;
    logic [63:0] bank_wdata;
    logic [63:0] bank_rdata;
    logic        cram_en, cram_we, rom_en;
    logic [18:0] cram_addr;
    logic [7:0]  cram_wdata, cram_rdata, rom_rdata;
    logic [14:0] rom_addr;
    logic [3:0]  status_in = 4'hA;
    logic        done_in = 0, fault_in = 0;
    logic [1:0]  cfg_sel;
    logic [3:0]  clk_prog;
    logic [2:0]  cmd_pulse;
    logic        irq;

    dual_bank_hub u_dual_bank_hub (
        .clk(clk), .rst_n(rst_n),
        .host_req(h_req), .host_we(h_we), .host_size(h_size), .host_addr(h_addr),
        .host_wdata(h_wdata), .host_ready(host_ready), .host_rdata(host_rdata),
        .core_run(core_run), .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr),
        .loc_be(loc_be), .loc_wdata(loc_wdata), .loc_gnt(loc_gnt),
        .bank_en(bank_en), .bank_we(bank_we), .bank_addr(bank_addr), .bank_be(bank_be),
        .bank_wdata(bank_wdata), .bank_rdata(bank_rdata),
        .cram_en(cram_en), .cram_we(cram_we), .cram_addr(cram_addr), .cram_wdata(cram_wdata),
        .cram_rdata(cram_rdata), .rom_en(rom_en), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .status_in(status_in), .done_in(done_in), .fault_in(fault_in),
        .cfg_sel(cfg_sel), .clk_prog(clk_prog), .cmd_pulse(cmd_pulse), .irq(irq)
    );

    // memory models: 64 words per bank, 64 bytes of configuration RAM
    logic [31:0] mem0 [64];
    logic [31:0] mem1 [64];
    logic [7:0]  cmem [64];
    logic [31:0] rd0 = 0, rd1 = 0;
    logic [7:0]  crd = 0, rrd = 0;
    assign bank_rdata = {rd1, rd0};
    assign cram_rdata = crd;
    assign rom_rdata  = rrd;

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem0[i] = '0; mem1[i] = '0; cmem[i] = '0;
        end
    end

    always @(posedge clk) begin
        if (bank_en[0]) begin
            if (bank_we[0]) for (int l = 0; l < 4; l++)
                if (bank_be[l]) mem0[bank_addr[5:0]][l*8 +: 8] <= bank_wdata[l*8 +: 8];
            rd0 <= mem0[bank_addr[5:0]];
        end
        if (bank_en[1]) begin
            if (bank_we[1]) for (int l = 0; l < 4; l++)
                if (bank_be[4+l]) mem1[bank_addr[23:18]][l*8 +: 8] <= bank_wdata[32+l*8 +: 8];
            rd1 <= mem1[bank_addr[23:18]];
        end
        if (cram_en) begin
            if (cram_we) cmem[cram_addr[5:0]] <= cram_wdata;
            crd <= cmem[cram_addr[5:0]];
        end
        if (rom_en) rrd <= rom_addr[7:0] ^ 8'h5A;
    end

    int n_cmp = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct {
        bit          cmp;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];
    bit drv_busy = 0;

    // monitor: pops one scoreboard item per completion
    always @(negedge clk) begin
        if (rst_n && host_ready) begin
            if (sb_q.size() == 0) chk(0, "R1 unexpected ready", 32'h1, 32'h0);
            else begin
                sb_item_t it;
                it = sb_q.pop_front();
                if (it.cmp) chk(host_rdata == it.exp, it.tag, host_rdata, it.exp);
            end
        end
    end

    // side monitors sampled between edges
    int deny_cnt = 0, cmd_cnt = 0;
    logic [2:0] cmd_val = 0;
    always begin
        @(negedge clk); #2;
        if (loc_req[1] && !loc_gnt[1]) deny_cnt++;
        if (cmd_pulse != 0) begin cmd_cnt++; cmd_val = cmd_pulse; end
    end

    task automatic host_op(input logic we, input logic [1:0] sz, input logic [23:0] a,
                           input logic [31:0] wd, input bit cmp, input logic [31:0] ex,
                           input string tg);
        sb_item_t it;
        it.cmp = cmp; it.exp = ex; it.tag = tg;
        sb_q.push_back(it);
        drv_busy = 1;
        @(negedge clk);
        h_req = 1; h_we = we; h_size = sz; h_addr = a; h_wdata = wd;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (host_ready) break;
        end
        h_req = 0;
        drv_busy = 0;
    endtask

    task automatic wr(input logic [1:0] sz, input logic [23:0] a, input logic [31:0] d);
        host_op(1, sz, a, d, 0, 0, "write");
    endtask
    task automatic rd(input logic [1:0] sz, input logic [23:0] a, input logic [31:0] ex, input string tg);
        host_op(0, sz, a, 0, 1, ex, tg);
    endtask

    initial begin
        #(8 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(host_ready == 0 && irq == 0, "R11 ready/irq after reset", {30'b0, host_ready, irq}, 0);
        chk(cfg_sel == 0 && clk_prog == 0 && cmd_pulse == 0, "R11 regs after reset",
            {23'b0, cfg_sel, clk_prog, cmd_pulse}, 0);
        chk(bank_en == 0, "R11 bank idle after reset", {30'b0, bank_en}, 0);

        // R1 word access in both banks
        wr(2, 24'h200000, 32'h0BADBEEF);
        wr(2, 24'h300008, 32'h13579BDF);
        rd(2, 24'h200000, 32'h0BADBEEF, "R1 bank0 word");
        rd(2, 24'h300008, 32'h13579BDF, "R1 bank1 word");

        // R2 big-endian byte and halfword lanes
        wr(0, 24'h200040, 32'h11);
        wr(0, 24'h200041, 32'h22);
        wr(0, 24'h200042, 32'h33);
        wr(0, 24'h200043, 32'h44);
        rd(2, 24'h200040, 32'h11223344, "R2 bytes assemble big-endian");
        rd(0, 24'h200042, 32'h33, "R2 byte read offset 2");
        wr(1, 24'h200042, 32'hBEEF);
        rd(2, 24'h200040, 32'h1122BEEF, "R2 half write offset 2");
        rd(1, 24'h200040, 32'h1122, "R2 half read offset 0");

        // R12 byte-wide regions
        wr(2, 24'h100005, 32'hFFFFFF9C);
        rd(2, 24'h100005, 32'h9C, "R12 config RAM byte");
        rd(0, 24'h000012, 32'h48, "R12 ROM byte");

        // R7 registers
        wr(0, 24'h400001, 32'h2);
        rd(0, 24'h400001, 32'h2, "R7 config select readback");
        chk(cfg_sel == 2, "R7 cfg_sel port", {30'b0, cfg_sel}, 2);
        wr(0, 24'h400003, 32'h9);
        chk(clk_prog == 9, "R7 clk_prog port", {28'b0, clk_prog}, 9);
        rd(0, 24'h400003, 32'h0, "R7 write-only reads zero");
        rd(0, 24'h400000, 32'hA, "R7 status reads input");

        // R8 command strobe
        cmd_cnt = 0;
        wr(0, 24'h400004, 32'h5);
        repeat (3) @(negedge clk);
        chk(cmd_cnt == 1, "R8 command pulse length", cmd_cnt, 1);
        chk(cmd_val == 5, "R8 command pulse value", {29'b0, cmd_val}, 5);

        // R4 mirror on and off
        wr(0, 24'h400005, 32'h1);
        wr(2, 24'h200010, 32'hCAFEF00D);
        rd(2, 24'h300010, 32'hCAFEF00D, "R4 mirror copy in bank1");
        rd(2, 24'h200010, 32'hCAFEF00D, "R4 mirror copy in bank0");
        wr(0, 24'h400005, 32'h0);
        wr(2, 24'h300014, 32'h11111111);
        wr(2, 24'h200014, 32'h22222222);
        rd(2, 24'h300014, 32'h11111111, "R4 mirror off leaves bank1");

        // R10 address errors and R9 cause handling
        rd(2, 24'h500000, 32'h0, "R10 unmapped reads zero");
        chk(irq == 1, "R9 irq on address error", {31'b0, irq}, 1);
        rd(0, 24'h400002, 32'h2, "R9 cause shows address error");
        chk(irq == 0, "R9 cause read clears irq", {31'b0, irq}, 0);
        wr(0, 24'h400000, 32'hF);
        rd(0, 24'h400002, 32'h2, "R10 write to status is error");
        wr(0, 24'h000001, 32'h7);
        rd(0, 24'h400002, 32'h2, "R10 write to ROM is error");

        // R3 misaligned word has no effect
        wr(2, 24'h200020, 32'h01020304);
        wr(2, 24'h200021, 32'hFFFFFFFF);
        rd(2, 24'h200020, 32'h01020304, "R3 misaligned write ignored");
        rd(0, 24'h400002, 32'h2, "R3 misaligned flags error");

        // R9 done and fault causes
        @(negedge clk); done_in = 1; @(negedge clk); done_in = 0;
        chk(irq == 1, "R9 irq on done", {31'b0, irq}, 1);
        rd(0, 24'h400002, 32'h1, "R9 cause done bit");
        @(negedge clk); fault_in = 1; @(negedge clk); fault_in = 0;
        rd(0, 24'h400002, 32'h4, "R9 cause fault bit");

        // R5 local write then host read of it
        core_run = 1;
        @(negedge clk);
        loc_req[1] = 1; loc_we[1] = 1; loc_addr[35:18] = 18'd7; loc_be[7:4] = 4'hF;
        loc_wdata[63:32] = 32'hA5A50FF0;
        @(negedge clk);
        chk(loc_gnt[1] == 1, "R5 local grant while running", {31'b0, loc_gnt[1]}, 1);
        loc_req[1] = 0; loc_we[1] = 0;
        rd(2, 24'h30001C, 32'hA5A50FF0, "R5 host sees local write");

        // R5 host waits while local holds bank0
        loc_req[0] = 1; loc_we[0] = 0; loc_addr[17:0] = 0; loc_be[3:0] = 4'hF;
        fork
            rd(2, 24'h200000, 32'h0BADBEEF, "R5 delayed host read");
        join_none
        repeat (4) @(negedge clk);
        chk(host_ready == 0, "R5 host stalled", {31'b0, host_ready}, 0);
        chk(loc_gnt[0] == 1, "R5 local keeps bank", {31'b0, loc_gnt[0]}, 1);
        loc_req[0] = 0;
        wait (!drv_busy);

        // R6 host wins when not running
        core_run = 0;
        loc_req[1] = 1; loc_we[1] = 0; loc_addr[35:18] = 0;
        @(negedge clk);
        deny_cnt = 0;
        wr(2, 24'h300024, 32'h00000005);
        loc_req[1] = 0;
        chk(deny_cnt >= 1, "R6 local denied during host issue", deny_cnt, 1);
        rd(2, 24'h300024, 32'h5, "R6 host write landed");

        wait (sb_q.size() == 0);
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule